// File: doc/BRIEF.md
# Write-Once Mode Control Register

This block is an 8-bit mode control register for a peripheral on a multiplexed address/data bus. It holds two live bits:

- **Test-mode flag.** Comes up from a strap input at reset. Software may only clear it. Once cleared, it stays cleared until the next reset.
- **Read-visibility inhibit flag.** Software may write it once, and only while the part is still in test mode. It is forced low when test mode is left. Its polarity is inverted: a low level means reads drive the external bus.

From the inhibit flag and the read strobe, the block produces a drive qualifier for the bus output buffers. The qualifier covers reads of this register and reads of a neighbouring address-mapping register.

Address decoding and the pads are outside the block. A decoder supplies one select line for this register and one for the mapping register. All pins are plain control and status levels, so there is no valid/ready handshake and no back-pressure. A write is a single-cycle strobe that the register always accepts.

Top module: `modectl_reg`

## Requirements
- R1: A reset (synchronous, `rst_n` low at a rising edge) loads the test-mode flag from `strap_test` and the visibility-inhibit flag from `strap_test`. It also re-arms the inhibit flag's single write.
- R2: A write with `wr_data[6]`=0 while test mode is set clears the test-mode flag at the next rising edge. A write with bit 6 = 1 never sets the flag.
- R3: Once the test-mode flag is zero, no write changes it. Only a reset sets it again.
- R4: While test mode is set, the first write to the register loads the inhibit flag from `wr_data[4]`. Every later write leaves the inhibit flag unchanged, even while still in test mode.
- R5: While test mode is clear, writes leave the inhibit flag unchanged.
- R6: A write that clears the test-mode flag forces the inhibit flag to zero at the same edge, and `wr_data[4]` of that write is ignored.
- R7: When `sel_ctl` is high, `rd_data` shows the test-mode flag at bit 6 and the inhibit flag at bit 4, with bits 7, 5, 3, 2, 1 and 0 reading zero. When `sel_ctl` is low, `rd_data` is all zero. Writes to the unimplemented bits have no effect.
- R8: `bus_drive` is high exactly when `rd_en` is high, `sel_ctl` or `sel_map` is high, and the inhibit flag is zero. The output is combinational, in the same cycle as the strobe.
- R9: A write has effect only when both `wr_en` and `sel_ctl` are high at a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_test | input | 1 | Mode strap, sampled while reset is low |
| sel_ctl | input | 1 | Decoded select of this register |
| sel_map | input | 1 | Decoded select of the mapping register |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of this register |
| test_mode | output | 1 | Test-mode flag level |
| vis_inhibit | output | 1 | Visibility-inhibit flag level |
| bus_drive | output | 1 | Enable for the external bus drivers |

## Verification
A write changes `test_mode`, `vis_inhibit` and the register's `rd_data` one rising edge after the write strobe is presented. `bus_drive` and `rd_data`, however, follow the select and read inputs within the same cycle.

The bench drives every input on the falling edge and samples every output on the following falling edge. That point is half a cycle after the write edge for registered results. It is the same cycle for the combinational read path. A bench model of the two flags and the write-once arm is advanced only after each write edge, so each expected value refers to the state that the edge just committed.

// File: rtl/modectl_pkg.sv
package modectl_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned TEST_POS = 6;
  localparam int unsigned VIS_POS  = 4;
  localparam logic [REG_W-1:0] LIVE_MASK = (REG_W'(1) << TEST_POS) | (REG_W'(1) << VIS_POS);

  typedef struct packed {
    logic test;
    logic vis;
  } mode_state_t;

  function automatic logic [REG_W-1:0] pack_reg(input mode_state_t s);
    logic [REG_W-1:0] v;
    v = '0;
    v[TEST_POS] = s.test;
    v[VIS_POS]  = s.vis;
    return v;
  endfunction
endpackage

// File: rtl/modectl_test_bit.sv
module modectl_test_bit #(
  parameter int unsigned W   = 8,
  parameter int unsigned POS = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strap,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic         test_q,
  output logic         leaving
);
  // Clear-only: a write of zero while set is the single legal transition.
  assign leaving = wr_hit && test_q && !wdata[POS];

  always_ff @(posedge clk) begin
    if (!rst_n)       test_q <= strap;
    else if (leaving) test_q <= 1'b0;
  end

  p_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !test_q |=> !test_q);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && test_q && !wdata[POS]) |=> !test_q);
endmodule

// File: rtl/modectl_vis_bit.sv
module modectl_vis_bit #(
  parameter int unsigned W   = 8,
  parameter int unsigned POS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strap,
  input  logic         wr_hit,
  input  logic         test_q,
  input  logic         leaving,
  input  logic [W-1:0] wdata,
  output logic         vis_q
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vis_q   <= strap;
      armed_q <= 1'b1;
    end else if (leaving) begin
      vis_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (wr_hit && test_q && armed_q) begin
      vis_q   <= wdata[POS];
      armed_q <= 1'b0;
    end
  end

  p_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !test_q |=> $stable(vis_q));
  p_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    leaving |=> !vis_q);
  p_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !leaving) |=> $stable(vis_q));
endmodule

// File: rtl/modectl_read_port.sv
module modectl_read_port
  import modectl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mode_state_t      st,
  input  logic             sel_ctl,
  input  logic             sel_map,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  output logic             bus_drive
);
  assign rd_data   = sel_ctl ? pack_reg(st) : '0;
  assign bus_drive = rd_en && (sel_ctl || sel_map) && !st.vis;

  p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE_MASK) == '0);
  p_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (rd_en && !st.vis));
endmodule

// File: rtl/modectl_reg.sv
module modectl_reg
  import modectl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_test,
  input  logic             sel_ctl,
  input  logic             sel_map,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             test_mode,
  output logic             vis_inhibit,
  output logic             bus_drive
);
  logic        wr_hit;
  logic        leaving;
  mode_state_t st;

  assign wr_hit = wr_en && sel_ctl;

  modectl_test_bit #(.W(REG_W), .POS(TEST_POS)) u_test (
    .clk(clk), .rst_n(rst_n), .strap(strap_test), .wr_hit(wr_hit),
    .wdata(wr_data), .test_q(st.test), .leaving(leaving));

  modectl_vis_bit #(.W(REG_W), .POS(VIS_POS)) u_vis (
    .clk(clk), .rst_n(rst_n), .strap(strap_test), .wr_hit(wr_hit),
    .test_q(st.test), .leaving(leaving), .wdata(wr_data), .vis_q(st.vis));

  modectl_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .st(st), .sel_ctl(sel_ctl), .sel_map(sel_map),
    .rd_en(rd_en), .rd_data(rd_data), .bus_drive(bus_drive));

  assign test_mode   = st.test;
  assign vis_inhibit = st.vis;

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel_ctl) |=> ($stable(test_mode) && $stable(vis_inhibit)));
endmodule

// File: tb/modectl_reg_test.sv
`timescale 1ns/1ps
module modectl_reg_test;
  logic clk = 1'b0;
  logic rst_n, strap_test, sel_ctl, sel_map, rd_en, wr_en;
  logic [7:0] wr_data, rd_data;
  logic test_mode, vis_inhibit, bus_drive;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic m_test, m_vis, m_armed;

  always #2.5 clk = ~clk;

  modectl_reg uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    sel_ctl = 1; sel_map = 0; rd_en = 1; wr_en = 0;
    #0.1;
    chk(req, test_mode, m_test);
    chk(req, vis_inhibit, m_vis);
    chk({req, " R7"}, rd_data, {1'b0, m_test, 1'b0, m_vis, 4'b0});
    chk({req, " R8"}, bus_drive, !m_vis);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 0; strap_test = s; wr_en = 0; sel_ctl = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; strap_test = ~s;
    m_test = s; m_vis = s; m_armed = 1;
  endtask

  // write with given select; state checked on next falling edge
  task automatic do_write(input logic [7:0] d, input logic sel);
    sel_ctl = sel; sel_map = 0; rd_en = 0; wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (sel && m_test) begin
      if (!d[6]) begin m_test = 0; m_vis = 0; m_armed = 0; end
      else if (m_armed) begin m_vis = d[4]; m_armed = 0; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; strap_test = 0; sel_ctl = 0; sel_map = 0;
    rd_en = 0; wr_en = 0; wr_data = 0;
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 256; w++) begin
        do_reset(s[0]);
        check_state("R1 reset");
        do_write(w[7:0], 1'b0);               // R9 unselected write ignored
        check_state("R9 no select");
        do_write(w[7:0], 1'b1);               // R2/R4/R6 first write
        check_state("R2 R4 R6 first write");
        do_write(w[7:0] ^ 8'h10, 1'b1);       // R4 second IRV write refused
        check_state("R4 second write");
        do_write(8'h50, 1'b1);                // R3 set attempt
        check_state("R3 R5 set attempt");
        do_write(8'h10, 1'b1);                // clear attempt / exit
        check_state("R5 R6 clear");
        do_write(8'hFF, 1'b1);
        check_state("R3 R5 R7 all ones");
        if (w % 32 == 0) begin
          for (int c = 0; c < 8; c++) begin
            rd_en = c[0]; sel_ctl = c[1]; sel_map = c[2];
            #0.1;
            chk("R8 drive", bus_drive, c[0] && (c[1] || c[2]) && !m_vis);
            chk("R7 deselect", rd_data, c[1] ? {1'b0, m_test, 1'b0, m_vis, 4'b0} : 0);
          end
        end
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule